// File: doc/BRIEF.md
# AES-128 Block Encryptor with Counter and Chaining Modes

This block encrypts one 128-bit block per operation with AES-128. The host loads a key, a counter and a text block one byte at a time through a simple write port. It then issues a control write that selects the mode and launches the operation. Three modes are available: plain encryption of the text, counter mode (the text XORed with the encrypted counter) and cipher block chaining (the text XORed with the previous chained output, then encrypted). An iterative engine runs one round per clock and expands the key on the fly. Every operation takes the same number of cycles, whatever the mode.

After reset the engine is locked. Software must first launch a built-in known-answer test. This test encrypts a fixed vector with a fixed key and compares the result with a stored ciphertext. Operation requests are accepted only after the test has passed. The key, counter and text registers keep their contents between operations, so a stream of blocks needs only the changing registers to be rewritten.

Top module: `aes_crypt_unit`

## Requirements
- R1: Writes go to byte registers. Key bytes use addresses 0x00 to 0x0F, counter bytes 0x10 to 0x1F and text bytes 0x20 to 0x2F. The byte at offset i within a group holds bits [127-8i : 120-8i] of that 128-bit value, so offset 0 is the most significant byte. All of these registers read as zero after reset.
- R2: A write to address 0x30 is the control write. Bit 0 requests an operation, bit 1 launches the self-test and bits [3:2] select the mode: 01 counter, 10 chaining, 00 or 11 plain. The request bit is not stored: one write yields at most one operation. Writes to 0x31 to 0x3F have no effect.
- R3: After reset, st_pass_o, st_fail_o, busy_o, done_o and result_o are all zero. An operation request made before a passing self-test is ignored.
- R4: The self-test encrypts plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f. On its final cycle it sets st_pass_o if the result equals 69c4e0d86a7b0430d8cdb78070b4c55a, and sets st_fail_o otherwise. Both flags are cleared when a self-test is launched, and they are never high together.
- R5: busy_o rises on the clock edge that accepts an operation or self-test and stays high for exactly 11 cycles. For an operation, done_o is a one-cycle pulse. It is high in the cycle after busy_o falls, which is the cycle in which result_o takes its new value.
- R6: In plain mode, result_o = AES(key, text).
- R7: In counter mode, result_o = text XOR AES(key, counter).
- R8: In chaining mode, result_o = AES(key, text XOR chain), and the result becomes the new chain value. The chain value is zero after reset and again after every self-test, and only chaining operations change it.
- R9: A request or self-test launch made while busy_o is high is ignored. The input registers are captured at acceptance, so later register writes do not alter the operation in flight.
- R10: The key, counter and text registers keep their values across operations. Consecutive operations can reuse a key loaded once.
- R11: result_o changes only together with a done_o pulse. A self-test neither pulses done_o nor alters result_o.
- R12: A control write with both bit 0 and bit 1 set launches only the self-test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 6 | Byte register address |
| wr_data_i | input | 8 | Byte write data |
| result_o | output | 128 | Result of the last completed operation |
| busy_o | output | 1 | Engine running an operation or the self-test |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| st_pass_o | output | 1 | Self-test passed, operations enabled |
| st_fail_o | output | 1 | Self-test produced a wrong ciphertext |

## Verification
The assertions check several timing and status rules on every cycle:
- done_o is a single-cycle pulse that follows exactly eleven busy cycles.
- result_o never moves without done_o.
- The pass and fail flags are exclusive and both clear at a self-test launch.
- A locked engine refuses requests.
- The chain value changes only when a chaining operation or a self-test finishes.

The cipher arithmetic itself can only be shown by the bench scenarios. These run published AES vectors through all three modes, chain two blocks, reuse a retained key, and show the chain value reset by a later self-test. Other behaviour also needs the bench: a request dropped while busy, the control-bit priority and the reserved mode code.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int BLK_W     = 128;
  localparam int BYTE_W    = 8;
  localparam int NBYTES    = BLK_W / BYTE_W;
  localparam int ROUNDS    = 10;
  localparam int LATENCY   = ROUNDS + 1;
  localparam int CNT_W     = $clog2(LATENCY + 1);
  localparam int ADDR_W    = 6;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 6'h30;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_CTR   = 2'b01,
    MODE_CBC   = 2'b10,
    MODE_ALT   = 2'b11
  } mode_e;

  localparam logic [BLK_W-1:0] KAT_KEY = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [BLK_W-1:0] KAT_PT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [BLK_W-1:0] KAT_CT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p2, p3, p6, p12, p14, p15, p30, p60, p120, p240;
    p2   = gf_mul(a, a);
    p3   = gf_mul(p2, a);
    p6   = gf_mul(p3, p3);
    p12  = gf_mul(p6, p6);
    p14  = gf_mul(p12, p2);
    p15  = gf_mul(p12, p3);
    p30  = gf_mul(p15, p15);
    p60  = gf_mul(p30, p30);
    p120 = gf_mul(p60, p60);
    p240 = gf_mul(p120, p120);
    return gf_mul(p240, p14);
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] rk_i,
  input  logic [7:0]       rcon_i,
  output logic [BLK_W-1:0] rk_o
);
  logic [31:0] w0, w1, w2, w3, rot, sub, n0, n1, n2, n3;

  assign w0  = rk_i[127:96];
  assign w1  = rk_i[95:64];
  assign w2  = rk_i[63:32];
  assign w3  = rk_i[31:0];
  assign rot = {w3[23:0], w3[31:24]};

  genvar b;
  generate
    for (b = 0; b < 4; b++) begin : g_sub
      assign sub[8*b +: 8] = sbox(rot[8*b +: 8]);
    end
  endgenerate

  assign n0   = w0 ^ sub ^ {rcon_i, 24'h000000};
  assign n1   = w1 ^ n0;
  assign n2   = w2 ^ n1;
  assign n3   = w3 ^ n2;
  assign rk_o = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  logic [7:0]       subb [NBYTES];
  logic [7:0]       shft [NBYTES];
  logic [BLK_W-1:0] shft_flat;
  logic [BLK_W-1:0] mixd;

  genvar i, c, r;
  generate
    for (i = 0; i < NBYTES; i++) begin : g_sub
      assign subb[i] = sbox(state_i[BLK_W-1-8*i -: 8]);
    end
    // byte (row r, column c) takes the byte of row r from column c+r
    for (c = 0; c < 4; c++) begin : g_col
      for (r = 0; r < 4; r++) begin : g_row
        assign shft[4*c+r] = subb[4*((c+r)%4)+r];
        assign shft_flat[BLK_W-1-8*(4*c+r) -: 8] = shft[4*c+r];
      end
    end
    for (c = 0; c < 4; c++) begin : g_mix
      logic [7:0] a0, a1, a2, a3;
      assign a0 = shft[4*c];
      assign a1 = shft[4*c+1];
      assign a2 = shft[4*c+2];
      assign a3 = shft[4*c+3];
      assign mixd[BLK_W-1-32*c -: 8]      = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      assign mixd[BLK_W-1-32*c-8 -: 8]    = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      assign mixd[BLK_W-1-32*c-16 -: 8]   = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      assign mixd[BLK_W-1-32*c-24 -: 8]   = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
  endgenerate

  assign state_o = (last_i ? shft_flat : mixd) ^ rkey_i;
endmodule

// File: rtl/aes_regbank.sv
module aes_regbank
  import aes_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [BLK_W-1:0]  key_o,
  output logic [BLK_W-1:0]  ctr_o,
  output logic [BLK_W-1:0]  txt_o
);
  localparam int NBANKS = 3;
  localparam int IDX_W  = $clog2(NBYTES);

  logic [BLK_W-1:0] bank_q [NBANKS];
  logic [1:0]       bank_sel;
  logic [IDX_W-1:0] byte_sel;

  assign bank_sel = wr_addr_i[ADDR_W-1 -: 2];
  assign byte_sel = wr_addr_i[IDX_W-1:0];

  genvar k, j;
  generate
    for (k = 0; k < NBANKS; k++) begin : g_bank
      for (j = 0; j < NBYTES; j++) begin : g_byte
        logic byte_en;
        assign byte_en = wr_en_i && (bank_sel == 2'(k)) && (byte_sel == IDX_W'(j));
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      bank_q[k][BLK_W-1-8*j -: 8] <= 8'h00;
          else if (byte_en) bank_q[k][BLK_W-1-8*j -: 8] <= wr_data_i;
        end
      end
    end
  endgenerate

  assign key_o = bank_q[0];
  assign ctr_o = bank_q[1];
  assign txt_o = bank_q[2];
endmodule

// File: rtl/aes_core.sv
module aes_core
  import aes_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             publish_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0] mask_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [BLK_W-1:0] fin_val_o,
  output logic             done_o,
  output logic [BLK_W-1:0] result_o
);
  logic [BLK_W-1:0] state_q, state_d, rk_q, rk_d, mask_q, mask_d, res_q, res_d;
  logic [BLK_W-1:0] rk_nx, rnd_out;
  logic [7:0]       rcon_q, rcon_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, pub_q, pub_d, done_q, done_d;
  logic             dp_en, res_en, last;

  aes_key_step u_key_step (
    .rk_i   (rk_q),
    .rcon_i (rcon_q),
    .rk_o   (rk_nx)
  );

  assign last = (cnt_q == CNT_W'(ROUNDS));

  aes_round u_round (
    .state_i (state_q),
    .rkey_i  (rk_nx),
    .last_i  (last),
    .state_o (rnd_out)
  );

  assign fin_o     = busy_q && last;
  assign fin_val_o = rnd_out ^ mask_q;

  always_comb begin
    state_d = state_q;
    rk_d    = rk_q;
    rcon_d  = rcon_q;
    cnt_d   = cnt_q;
    mask_d  = mask_q;
    pub_d   = pub_q;
    busy_d  = busy_q;
    res_d   = res_q;
    done_d  = 1'b0;
    res_en  = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        state_d = state_q ^ rk_q;
      end else begin
        state_d = rnd_out;
        rk_d    = rk_nx;
        rcon_d  = xtime(rcon_q);
      end
      cnt_d = cnt_q + 1'b1;
      if (fin_o) begin
        busy_d = 1'b0;
        if (pub_q) begin
          res_d  = fin_val_o;
          res_en = 1'b1;
          done_d = 1'b1;
        end
      end
    end else if (launch_i) begin
      busy_d  = 1'b1;
      state_d = blk_i;
      rk_d    = key_i;
      rcon_d  = 8'h01;
      cnt_d   = '0;
      mask_d  = mask_i;
      pub_d   = publish_i;
    end
  end

  assign dp_en = busy_q | launch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      rk_q    <= '0;
      rcon_q  <= 8'h00;
      cnt_q   <= '0;
      mask_q  <= '0;
      pub_q   <= 1'b0;
    end else if (dp_en) begin
      state_q <= state_d;
      rk_q    <= rk_d;
      rcon_q  <= rcon_d;
      cnt_q   <= cnt_d;
      mask_q  <= mask_d;
      pub_q   <= pub_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R5
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q, 1) && $past(busy_q, 11) && !$past(busy_q, 12)));
  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(res_q));
endmodule

// File: rtl/aes_crypt_unit.sv
module aes_crypt_unit
  import aes_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [BLK_W-1:0]  result_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              st_pass_o,
  output logic              st_fail_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [BLK_W-1:0] key_r, ctr_r, txt_r;
  logic [BLK_W-1:0] core_key, core_blk, core_mask, fin_val, chain_q, chain_d;
  logic             ctrl_wr, req_st, req_op, st_go, op_go, launch;
  logic             busy, fin;
  logic             pass_q, pass_d, fail_q, fail_d;
  logic             job_st_q, job_st_d, job_cbc_q, job_cbc_d;
  logic             job_en, chain_en;
  mode_e            req_mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  aes_regbank u_regbank (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .key_o     (key_r),
    .ctr_o     (ctr_r),
    .txt_o     (txt_r)
  );

  assign ctrl_wr  = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign req_st   = ctrl_wr && wr_data_i[1];
  assign req_op   = ctrl_wr && wr_data_i[0] && !wr_data_i[1];
  assign req_mode = mode_e'(wr_data_i[3:2]);
  assign st_go    = req_st && !busy;
  assign op_go    = req_op && !busy && pass_q;
  assign launch   = st_go | op_go;

  always_comb begin
    core_key  = key_r;
    core_blk  = txt_r;
    core_mask = '0;
    if (st_go) begin
      core_key = KAT_KEY;
      core_blk = KAT_PT;
    end else begin
      case (req_mode)
        MODE_CTR: begin
          core_blk  = ctr_r;
          core_mask = txt_r;
        end
        MODE_CBC: core_blk = txt_r ^ chain_q;
        default:  core_blk = txt_r;
      endcase
    end
  end

  aes_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .launch_i  (launch),
    .publish_i (op_go),
    .key_i     (core_key),
    .blk_i     (core_blk),
    .mask_i    (core_mask),
    .busy_o    (busy),
    .fin_o     (fin),
    .fin_val_o (fin_val),
    .done_o    (done_o),
    .result_o  (result_o)
  );

  always_comb begin
    pass_d    = pass_q;
    fail_d    = fail_q;
    chain_d   = chain_q;
    job_st_d  = job_st_q;
    job_cbc_d = job_cbc_q;
    job_en    = launch;
    chain_en  = 1'b0;
    if (launch) begin
      job_st_d  = st_go;
      job_cbc_d = op_go && (req_mode == MODE_CBC);
    end
    if (st_go) begin
      pass_d = 1'b0;
      fail_d = 1'b0;
    end
    if (fin) begin
      if (job_st_q) begin
        pass_d   = (fin_val == KAT_CT);
        fail_d   = (fin_val != KAT_CT);
        chain_d  = '0;
        chain_en = 1'b1;
      end else if (job_cbc_q) begin
        chain_d  = fin_val;
        chain_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      job_st_q  <= 1'b0;
      job_cbc_q <= 1'b0;
    end else if (job_en) begin
      job_st_q  <= job_st_d;
      job_cbc_q <= job_cbc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (chain_en) chain_q <= chain_d;
  end

  assign busy_o    = busy;
  assign st_pass_o = pass_q;
  assign st_fail_o = fail_q;

  // R3
  locked_req_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_op && !pass_q && !busy) |=> !busy);
  // R4
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(pass_q && fail_q));
  // R4
  st_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    st_go |=> (busy && !pass_q && !fail_q));
  // R8
  chain_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (chain_q != $past(chain_q)) |-> $past(fin && (job_st_q || job_cbc_q)));
endmodule

// File: tb/test_aes_crypt_unit.sv
module test_aes_crypt_unit;
  localparam logic [127:0] K_A  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P_A  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C_A  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] K_B  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P_B  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C_B  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] TXT  = 128'h0123456789abcdeffedcba9876543210;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [127:0] result;
  logic         busy, done, st_pass, st_fail;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    logic [127:0] val;
    int           at;
    string        req;
  } exp_t;
  exp_t exp_q[$];

  aes_crypt_unit i_aes_crypt_unit (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .result_o  (result),
    .busy_o    (busy),
    .done_o    (done),
    .st_pass_o (st_pass),
    .st_fail_o (st_fail)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [5:0] base, input logic [127:0] v);
    for (int i = 0; i < 16; i++) wr(base + 6'(i), v[127-8*i -: 8]);
  endtask

  // driver: pushes the expected result, then issues the request
  task automatic start_op(input logic [7:0] ctl, input logic [127:0] v, input string req);
    exp_t e;
    @(negedge clk);
    e.val = v;
    e.at  = cyc + 12;
    e.req = req;
    exp_q.push_back(e);
    wr_en = 1'b1;
    wr_addr = 6'h30;
    wr_data = ctl;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // monitor: pops and compares on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R5: actual unexpected done expected no done (cycle %0d)", cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, result, e.val);
        check("R5 latency", 128'(cyc), 128'(e.at));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3 reset state
    check("R3 busy", 128'(busy), 0);
    check("R3 done", 128'(done), 0);
    check("R3 pass", 128'(st_pass), 0);
    check("R3 fail", 128'(st_fail), 0);
    check("R3 result", result, 0);

    // R1 byte layout, R3 locked engine ignores a request
    load(6'h00, K_A);
    load(6'h20, P_A);
    wr(6'h30, 8'h01);
    check("R3 locked busy", 128'(busy), 0);
    repeat (14) @(negedge clk);
    check("R3 locked pass", 128'(st_pass), 0);

    // R4 self-test: 11 busy cycles, verdict on the last one
    wr(6'h30, 8'h02);
    check("R4 busy at launch", 128'(busy), 1);
    repeat (10) @(negedge clk);
    check("R4 busy last", 128'(busy), 1);
    check("R4 pass early", 128'(st_pass), 0);
    @(negedge clk);
    check("R4 busy off", 128'(busy), 0);
    check("R4 pass", 128'(st_pass), 1);
    check("R4 fail", 128'(st_fail), 0);
    check("R11 result after test", result, 0);

    // R6 R1 plain mode
    start_op(8'h01, C_A, "R6 plain");

    // R9 request and text change while busy are ignored
    @(negedge clk);
    exp_q.push_back('{C_A, cyc + 12, "R9 busy ignore"});
    wr_en = 1'b1; wr_addr = 6'h30; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    wr(6'h20, 8'hff);
    wr(6'h30, 8'h05);
    wr(6'h30, 8'h02);
    repeat (12) @(negedge clk);
    check("R9 idle", 128'(busy), 0);
    check("R9 pass kept", 128'(st_pass), 1);

    // R10 key loaded once, reused for plain then counter
    load(6'h00, K_B);
    load(6'h20, P_B);
    start_op(8'h01, C_B, "R10 plain");
    load(6'h10, P_B);
    load(6'h20, TXT);
    start_op(8'h05, TXT ^ C_B, "R7 counter");

    // R8 chaining: first block with zero chain, counter op between
    load(6'h20, P_B);
    start_op(8'h09, C_B, "R8 chain first");
    start_op(8'h05, P_B ^ C_B, "R7 counter text");
    load(6'h20, P_B ^ C_B);
    start_op(8'h09, C_B, "R8 chain second");

    // R2 reserved mode code behaves as plain, reserved address ignored
    load(6'h20, P_B);
    start_op(8'h0d, C_B, "R2 mode 11");
    wr(6'h31, 8'h01);
    check("R2 reserved addr", 128'(busy), 0);

    // R12 both bits: self-test only; R11 result untouched; R8 chain cleared
    hold = result;
    wr(6'h30, 8'h0b);
    repeat (12) @(negedge clk);
    check("R12 pass", 128'(st_pass), 1);
    check("R11 result kept", result, hold);
    start_op(8'h09, C_B, "R8 chain cleared");

    repeat (4) @(negedge clk);
    check("R5 queue drained", 128'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule